// File: doc/BRIEF.md
# Segment-Mirroring Address Decoder

This block decodes 32-bit bus addresses from a small I/O processor that has no TLB. The three top address bits are dropped, so every kernel or user segment maps onto the same 512 MB physical space. Bits [28:16] of the folded address then give a 64 KB page number. That page number picks one of nine target regions: main RAM, boot ROM, a second ROM, the scratchpad, the hardware register page, the inter-processor mailbox, an external device window, the audio unit, or a second hardware register group.

Each accepted access raises one bit of a one-hot select vector and gives the byte offset inside the chosen region. An access to a page outside the map raises an unmapped flag and no select, so the data path can return zero on reads. Writes are dropped for the read-only ROMs. While the cache-isolate flag is set, writes to the memory regions are dropped as well. The outputs pass through one register stage by default. A parameter removes that stage and makes the decoder purely combinational.

Top module: `seg_addr_decoder`

## Requirements
- R1: Address bits [31:29] have no effect on any output. For example, 0xBFC0_1234 decodes exactly like 0x1FC0_1234.
- R2: Pages 0x0000–0x007F select RAM (sel bit 0). The offset is folded address bits [20:0], so the 2 MB array repeats four times across the 8 MB window.
- R3: Pages 0x1FC0–0x1FFF select the boot ROM (sel bit 1) with offset bits [21:0]. Pages 0x1E00–0x1E03 select the second ROM (sel bit 2) with offset bits [17:0].
- R4: A write alone to either ROM raises no select, does not assert wr_o and does not assert unmapped_o.
- R5: On page 0x1F80, offsets below 0x1000 select the scratchpad (sel bit 3) with offset bits [11:0]. Offsets at or above 0x1000 select the hardware registers (sel bit 4) with offset bits [15:0].
- R6: Page 0x1D00 selects the mailbox (sel bit 5) with offset bits [7:0] only, so 256 bytes repeat across the page.
- R7: Page 0x1000 selects the external device window (sel bit 6). Page 0x1F90 selects the audio unit (sel bit 7). Page 0x1F40 selects the second register group (sel bit 8). All three use offset bits [15:0].
- R8: While isolate_i is high, a write alone to RAM or the scratchpad raises no select and no wr_o. Reads are not affected, and writes to register pages are not affected.
- R9: A read or write to any page not listed above asserts unmapped_o, with no select and an offset of zero.
- R10: With neither rd_i nor wr_i high, all outputs are zero. Whenever no select bit is set, offset_o is zero.
- R11: With the default OUT_REG=1, outputs appear one clock after the inputs are sampled. During reset they are all zero.
- R12: wr_o is high exactly when wr_i is high and a select is raised for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| isolate_i | input | 1 | Cache-isolate flag; blocks memory writes |
| sel_o | output | 9 | One-hot region select |
| offset_o | output | 22 | Byte offset inside the selected region |
| wr_o | output | 1 | Accepted write |
| unmapped_o | output | 1 | Access to an unmapped page |

## Verification
Every output is due exactly one rising edge after its inputs are sampled. The bench drives a new address and new strobes on each falling edge. It compares all four outputs at the next falling edge, after the register stage has taken the value and before the following stimulus is applied. The expected values come from a bench function that walks the page table from the requirements. Directed cases cover the region boundaries, the scratchpad split, mailbox wrap, ROM writes and isolated writes. Seeded random addresses, with random top bits and random strobes, fill in the rest.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int ADDR_W = 32;
  localparam int PHYS_W = 29;
  localparam int PAGE_W = 13;
  localparam int PG_OFF_W = 16;
  localparam int OFF_W = 22;
  localparam int NREG = 9;

  localparam int RG_RAM  = 0;
  localparam int RG_BROM = 1;
  localparam int RG_ROM2 = 2;
  localparam int RG_SPAD = 3;
  localparam int RG_HWR  = 4;
  localparam int RG_MBOX = 5;
  localparam int RG_EXT  = 6;
  localparam int RG_AUD  = 7;
  localparam int RG_HW2  = 8;

  // regions whose writes are always dropped
  localparam logic [NREG-1:0] RO_MASK = (NREG'(1) << RG_BROM) | (NREG'(1) << RG_ROM2);
  // regions whose writes are dropped under cache isolation
  localparam logic [NREG-1:0] MEM_MASK = (NREG'(1) << RG_RAM) | (NREG'(1) << RG_SPAD);

  function automatic int region_off_bits(input int rg);
    case (rg)
      RG_RAM:  return 21;
      RG_BROM: return 22;
      RG_ROM2: return 18;
      RG_SPAD: return 12;
      RG_MBOX: return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/seg_fold.sv
module seg_fold
  import seg_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic [PAGE_W-1:0] page_o
);
  assign phys_o = addr_i[PHYS_W-1:0];
  assign page_o = phys_o[PHYS_W-1:PG_OFF_W];
endmodule

// File: rtl/seg_page_decode.sv
module seg_page_decode
  import seg_dec_pkg::*;
#(
  parameter int RAM_BASE   = 'h0000,
  parameter int RAM_PAGES  = 128,
  parameter int BROM_BASE  = 'h1FC0,
  parameter int BROM_PAGES = 64,
  parameter int ROM2_BASE  = 'h1E00,
  parameter int ROM2_PAGES = 4,
  parameter int HW_PAGE    = 'h1F80,
  parameter int SPAD_BYTES = 'h1000,
  parameter int MBOX_PAGE  = 'h1D00,
  parameter int EXT_PAGE   = 'h1000,
  parameter int AUD_PAGE   = 'h1F90,
  parameter int HW2_PAGE   = 'h1F40
) (
  input  logic [PHYS_W-1:0] phys_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [NREG-1:0]   hit_o
);
  int pg;
  int pofs;
  always_comb begin
    pg   = int'(page_i);
    pofs = int'(phys_i[PG_OFF_W-1:0]);
    hit_o = '0;
    hit_o[RG_RAM]  = (pg >= RAM_BASE)  && (pg < RAM_BASE + RAM_PAGES);
    hit_o[RG_BROM] = (pg >= BROM_BASE) && (pg < BROM_BASE + BROM_PAGES);
    hit_o[RG_ROM2] = (pg >= ROM2_BASE) && (pg < ROM2_BASE + ROM2_PAGES);
    hit_o[RG_SPAD] = (pg == HW_PAGE) && (pofs < SPAD_BYTES);
    hit_o[RG_HWR]  = (pg == HW_PAGE) && (pofs >= SPAD_BYTES);
    hit_o[RG_MBOX] = (pg == MBOX_PAGE);
    hit_o[RG_EXT]  = (pg == EXT_PAGE);
    hit_o[RG_AUD]  = (pg == AUD_PAGE);
    hit_o[RG_HW2]  = (pg == HW2_PAGE);
  end
endmodule

// File: rtl/seg_access_gate.sv
module seg_access_gate
  import seg_dec_pkg::*;
(
  input  logic [PHYS_W-1:0] phys_i,
  input  logic [NREG-1:0]   hit_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              isolate_i,
  output logic [NREG-1:0]   sel_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              wr_o,
  output logic              unmapped_o
);
  logic [NREG-1:0] wr_ok;
  logic [OFF_W-1:0] phys_ext;

  assign phys_ext = phys_i[OFF_W-1:0];

  always_comb begin
    wr_ok = hit_i & ~RO_MASK & ~(isolate_i ? MEM_MASK : '0);
    for (int r = 0; r < NREG; r++)
      sel_o[r] = hit_i[r] & (rd_i | (wr_i & wr_ok[r]));
    wr_o       = wr_i & (|sel_o);
    unmapped_o = (rd_i | wr_i) & ~(|hit_i);
    offset_o   = '0;
    for (int r = 0; r < NREG; r++)
      if (sel_o[r])
        offset_o = offset_o | (phys_ext & OFF_W'((64'd1 << region_off_bits(r)) - 64'd1));
  end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
  import seg_dec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              isolate_i,
  output logic [8:0]        sel_o,
  output logic [21:0]       offset_o,
  output logic              wr_o,
  output logic              unmapped_o
);
  logic [PHYS_W-1:0] phys;
  logic [PAGE_W-1:0] page;
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   g_sel;
  logic [OFF_W-1:0]  g_off;
  logic              g_wr;
  logic              g_unm;

  seg_fold u_fold (
    .addr_i (addr_i),
    .phys_o (phys),
    .page_o (page)
  );

  seg_page_decode u_pdec (
    .phys_i (phys),
    .page_i (page),
    .hit_o  (hit)
  );

  seg_access_gate u_gate (
    .phys_i     (phys),
    .hit_i      (hit),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .isolate_i  (isolate_i),
    .sel_o      (g_sel),
    .offset_o   (g_off),
    .wr_o       (g_wr),
    .unmapped_o (g_unm)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sel_o      <= '0;
          offset_o   <= '0;
          wr_o       <= 1'b0;
          unmapped_o <= 1'b0;
        end else begin
          sel_o      <= g_sel;
          offset_o   <= g_off;
          wr_o       <= g_wr;
          unmapped_o <= g_unm;
        end
      end
    end else begin : g_comb
      assign sel_o      = g_sel;
      assign offset_o   = g_off;
      assign wr_o       = g_wr;
      assign unmapped_o = g_unm;
    end
  endgenerate

  p_onehot_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_unmapped_nosel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (sel_o == '0));
  p_rom_nowrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && (hit[RG_BROM] || hit[RG_ROM2])) |-> (g_sel == '0 && !g_wr && !g_unm));
  p_isolate_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isolate_i && wr_i && !rd_i) |-> !(g_sel[RG_RAM] || g_sel[RG_SPAD]));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> (g_sel == '0 && !g_unm && !g_wr && g_off == '0));
  p_wr_needs_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (sel_o != '0));
endmodule

// File: tb/sim_seg_addr_decoder.sv
module sim_seg_addr_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        isolate_i = 1'b0;
  logic [8:0]  sel_o;
  logic [21:0] offset_o;
  logic        wr_o;
  logic        unmapped_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  seg_addr_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .isolate_i(isolate_i), .sel_o(sel_o), .offset_o(offset_o), .wr_o(wr_o),
    .unmapped_o(unmapped_o)
  );

  typedef struct packed {
    logic [8:0]  sel;
    logic [21:0] off;
    logic        wr;
    logic        unm;
  } exp_t;

  function automatic exp_t model(input logic [31:0] a, input logic rd, input logic wr, input logic iso);
    exp_t e;
    int pg, ofs, rg, bits;
    logic ro, mem, ok;
    e = '0;
    pg = int'(a[28:16]);
    ofs = int'(a[15:0]);
    rg = -1; bits = 0;
    if (pg < 'h80) begin rg = 0; bits = 21; end
    else if (pg >= 'h1FC0) begin rg = 1; bits = 22; end
    else if (pg >= 'h1E00 && pg < 'h1E04) begin rg = 2; bits = 18; end
    else if (pg == 'h1F80) begin
      if (ofs < 'h1000) begin rg = 3; bits = 12; end else begin rg = 4; bits = 16; end
    end
    else if (pg == 'h1D00) begin rg = 5; bits = 8; end
    else if (pg == 'h1000) begin rg = 6; bits = 16; end
    else if (pg == 'h1F90) begin rg = 7; bits = 16; end
    else if (pg == 'h1F40) begin rg = 8; bits = 16; end
    if (!rd && !wr) return e;
    if (rg < 0) begin e.unm = 1'b1; return e; end
    ro  = (rg == 1 || rg == 2);
    mem = (rg == 0 || rg == 3);
    ok  = rd || (wr && !ro && !(iso && mem));
    if (ok) begin
      e.sel[rg] = 1'b1;
      e.off = 22'(a[21:0] & 22'((64'd1 << bits) - 1));
      e.wr = wr;
    end
    return e;
  endfunction

  task automatic check(input string req, input exp_t e);
    n_chk++;
    if (sel_o !== e.sel || offset_o !== e.off || wr_o !== e.wr || unmapped_o !== e.unm) begin
      n_bad++;
      $display("FAIL %s: got sel=%h off=%h wr=%b unm=%b exp sel=%h off=%h wr=%b unm=%b",
               req, sel_o, offset_o, wr_o, unmapped_o, e.sel, e.off, e.wr, e.unm);
    end
  endtask

  // drive on falling edge, result due after next rising edge, compare on next falling edge
  task automatic access(input string req, input logic [31:0] a, input logic rd, input logic wr, input logic iso);
    addr_i = a; rd_i = rd; wr_i = wr; isolate_i = iso;
    @(negedge clk_i);
    check(req, model(a, rd, wr, iso));
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    exp_t e0;
    e0 = '0;
    addr_i = 32'h1FC0_0000; rd_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R11 reset", e0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    access("R1 fold kseg1", 32'hBFC0_1234, 1, 0, 0);
    access("R1 fold kseg0", 32'h9FC0_1234, 1, 0, 0);
    access("R2 ram base", 32'h0000_0010, 1, 0, 0);
    access("R2 ram mirror", 32'h8060_ABCD, 0, 1, 0);
    access("R2 ram top", 32'h007F_FFFC, 1, 0, 0);
    access("R9 ram edge+1", 32'h0080_0000, 1, 0, 0);
    access("R3 brom last", 32'h1FFF_FFFF, 1, 0, 0);
    access("R3 rom2", 32'h1E03_0042, 1, 0, 0);
    access("R9 rom2 edge+1", 32'h1E04_0000, 1, 0, 0);
    access("R4 brom write", 32'hBFC0_0100, 0, 1, 0);
    access("R4 rom2 write", 32'h1E00_0100, 0, 1, 0);
    access("R5 spad", 32'h1F80_0FFF, 1, 0, 0);
    access("R5 hwreg", 32'h1F80_1000, 0, 1, 0);
    access("R6 mbox wrap", 32'hBD00_F7A4, 1, 0, 0);
    access("R7 ext", 32'h1000_1234, 0, 1, 0);
    access("R7 audio", 32'h1F90_0200, 1, 0, 0);
    access("R7 hw2", 32'h1F40_0005, 0, 1, 0);
    access("R8 iso ram write", 32'h0001_0000, 0, 1, 1);
    access("R8 iso spad write", 32'h1F80_0020, 0, 1, 1);
    access("R8 iso ram read", 32'h0001_0000, 1, 0, 1);
    access("R8 iso hwreg write", 32'h1F80_1100, 0, 1, 1);
    access("R9 unmapped", 32'h1234_5678, 0, 1, 0);
    access("R10 idle", 32'h0000_1000, 0, 0, 0);
    access("R12 write ack", 32'h1D00_0010, 0, 1, 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      a = $urandom;
      case (k)
        0: a[28:16] = 13'($urandom_range(0, 'h7F));
        1: a[28:16] = 13'($urandom_range('h1FC0, 'h1FFF));
        2: a[28:16] = 13'($urandom_range('h1E00, 'h1E03));
        3: a[28:16] = 13'h1F80;
        4: a[28:16] = 13'h1D00;
        5: a[28:16] = 13'h1000;
        6: a[28:16] = 13'h1F90;
        7: a[28:16] = 13'h1F40;
        default: ;
      endcase
      access("R1-random", a, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule